// File: doc/BRIEF.md
# Banked Peripheral Interrupt Controller

This block collects single-bit event lines from peripherals and sorts them into four banks of four sources. A rising edge on a source sets that source's pending flag. Each bank has an enable mask. A bank raises its own request line whenever a pending flag meets a set enable bit. The four request lines feed CPU interrupt levels 3 to 6: the lowest bank feeds level 3 and the highest feeds level 6.

Software reaches the block through a byte-wide register bus, and reads return at once. Each bank has a flag register and an enable register. A flag bit clears when software writes a one to it. The enable register is never loaded directly. Bit 7 of the write data picks whether the data bits that are one set enable bits or clear them. This lets independent drivers change their own sources without a read-modify-write.

Top module: `irqc_top`

## Requirements
- R1: Bank b (b = 0..3) sits at address 0x30 + 0x10·b. Its flag register is at offset 0x0 in the bank and its enable register at offset 0x4. A write to any other address changes no state, and a read of any other address returns 0x00.
- R2: A 0→1 transition on source line 4·b+i between two clock edges sets flag bit i of bank b, whether or not that source is enabled. A source held high sets the flag only once.
- R3: A flag bit, once set, stays set until a flag-register write with a 1 in that bit position. Writing a 0 in a bit position leaves that flag unchanged.
- R4: An enable-register write with data bit 7 = 1 sets every enable bit whose data bit (3..0) is 1 and leaves the others unchanged.
- R5: An enable-register write with data bit 7 = 0 clears every enable bit whose data bit (3..0) is 1 and leaves the others unchanged.
- R6: If a new source edge and a clearing write reach the same flag bit at the same clock edge, the flag stays set.
- R7: Request bit b is high exactly when bank b has some flag bit that is set and also enabled. The request falls in the cycle that follows the write that removes the last such bit, and it can only fall after a register write.
- R8: Reads place the four status bits in data bits 3..0 and return 0 in bits 7..4. Reset clears all flags, all enables and all requests.
- R9: Writing 0x0F to a bank's enable register and then to its flag register leaves both registers at zero and drops that bank's request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| src_evt | input | 16 | Source lines, bank b in bits 4b+3..4b |
| irq_lvl | output | 4 | Request per bank, bit b to CPU level 3+b |

## Verification
The assertions assume that the source lines are synchronous to the clock and stay stable across each edge. They also assume that a write strobe lasts exactly one cycle per access, so that each edge sees one complete bus operation. The bench changes sources and bus signals only on falling edges, and it holds the strobe for a single cycle per vector. It returns every source to zero before it applies reset, so no stale edge is seen when reset is released.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_BANKS    = 4;
    localparam int SRC_PER_BANK = 4;
    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 8;
    localparam int FIRST_PAGE   = 3;   // page of bank 0 in addr[7:4]
    localparam int FLAG_SLOT    = 0;   // in-page slot of flag register
    localparam int ENA_SLOT     = 4;   // in-page slot of enable register
    localparam int POL_BIT      = 7;   // enable write: 1 = set, 0 = clear
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int NB         = NUM_BANKS,
    parameter int AW         = ADDR_W,
    parameter int FIRST      = FIRST_PAGE,
    parameter int FLAG_OFS   = FLAG_SLOT,
    parameter int ENA_OFS    = ENA_SLOT,
    localparam int BW        = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          sel_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    output logic [NB-1:0] flag_wr_o,
    output logic [NB-1:0] ena_wr_o,
    output logic          hit_o,
    output logic [BW-1:0] bank_o,
    output logic          is_ena_o
);
    logic [AW-5:0] page;
    logic [3:0]    slot;
    logic          slot_flag;
    logic          slot_ena;

    assign page      = addr_i[AW-1:4];
    assign slot      = addr_i[3:0];
    assign slot_flag = (int'(slot) == FLAG_OFS);
    assign slot_ena  = (int'(slot) == ENA_OFS);
    assign is_ena_o  = slot_ena;

    for (genvar g = 0; g < NB; g++) begin : g_strobe
        logic page_hit;
        assign page_hit     = (int'(page) == FIRST + g);
        assign flag_wr_o[g] = sel_i && we_i && page_hit && slot_flag;
        assign ena_wr_o[g]  = sel_i && we_i && page_hit && slot_ena;
    end

    always_comb begin
        hit_o  = 1'b0;
        bank_o = '0;
        for (int b = 0; b < NB; b++) begin
            if (int'(page) == FIRST + b && (slot_flag || slot_ena) && sel_i) begin
                hit_o  = 1'b1;
                bank_o = BW'(b);
            end
        end
    end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic         flag_wr_i,
    input  logic         ena_wr_i,
    input  logic         pol_i,
    input  logic [N-1:0] wmask_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] ena_o,
    output logic         req_o
);
    typedef struct packed {
        logic [N-1:0] src_prev;
        logic [N-1:0] flag;
        logic [N-1:0] ena;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [N-1:0] rise;

    always_comb begin
        rise          = src_i & ~st_q.src_prev;
        st_d          = st_q;
        st_d.src_prev = src_i;
        if (flag_wr_i)
            st_d.flag = st_q.flag & ~wmask_i;
        st_d.flag = st_d.flag | rise;          // new event beats clear
        if (ena_wr_i)
            st_d.ena = pol_i ? (st_q.ena | wmask_i) : (st_q.ena & ~wmask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign ena_o  = st_q.ena;
    assign req_o  = |(st_q.flag & st_q.ena);

    // R2 / R6: an edge always lands in the flag, clear or not
    a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_i & ~st_q.src_prev) != '0) |=>
            ((flag_o & $past(src_i & ~st_q.src_prev)) == $past(src_i & ~st_q.src_prev)));

    // R3: flags only fall through a flag write
    a_r3_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr_i |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

    // R4
    a_r4_ena_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_wr_i && pol_i) |=> ((ena_o & $past(wmask_i)) == $past(wmask_i)));

    // R5
    a_r5_ena_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_wr_i && !pol_i) |=> ((ena_o & $past(wmask_i)) == '0));

    // R7: request can only drop after a register write
    a_r7_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_wr_i && !ena_wr_i) |=> !($past(req_o) && !req_o));
endmodule

// File: rtl/irqc_readmux.sv
module irqc_readmux #(
    parameter int NB = 4,
    parameter int N  = 4,
    parameter int DW = 8,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [NB-1:0][N-1:0] flags_i,
    input  logic [NB-1:0][N-1:0] enas_i,
    input  logic                 hit_i,
    input  logic [BW-1:0]        bank_i,
    input  logic                 is_ena_i,
    output logic [DW-1:0]        rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (hit_i)
            rdata_o[N-1:0] = is_ena_i ? enas_i[bank_i] : flags_i[bank_i];
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NB  = NUM_BANKS,
    parameter int N   = SRC_PER_BANK,
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int POL = POL_BIT,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NB*N-1:0] src_evt,
    output logic [NB-1:0]   irq_lvl
);
    logic [NB-1:0]         flag_wr;
    logic [NB-1:0]         ena_wr;
    logic                  rd_hit;
    logic [BW-1:0]         rd_bank;
    logic                  rd_ena;
    logic [NB-1:0][N-1:0]  flags;
    logic [NB-1:0][N-1:0]  enas;
    logic                  unused_wdata;

    assign unused_wdata = ^bus_wdata[POL-1:N];

    irqc_decode #(.NB(NB), .AW(AW)) u_dec (
        .sel_i     (bus_sel),
        .we_i      (bus_we),
        .addr_i    (bus_addr),
        .flag_wr_o (flag_wr),
        .ena_wr_o  (ena_wr),
        .hit_o     (rd_hit),
        .bank_o    (rd_bank),
        .is_ena_o  (rd_ena)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        irqc_bank #(.N(N)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (src_evt[g*N +: N]),
            .flag_wr_i (flag_wr[g]),
            .ena_wr_i  (ena_wr[g]),
            .pol_i     (bus_wdata[POL]),
            .wmask_i   (bus_wdata[N-1:0]),
            .flag_o    (flags[g]),
            .ena_o     (enas[g]),
            .req_o     (irq_lvl[g])
        );
    end

    irqc_readmux #(.NB(NB), .N(N), .DW(DW)) u_rd (
        .flags_i  (flags),
        .enas_i   (enas),
        .hit_i    (rd_hit && !bus_we),
        .bank_i   (rd_bank),
        .is_ena_i (rd_ena),
        .rdata_o  (bus_rdata)
    );
endmodule

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] src_evt = '0;
    logic [3:0]  irq_lvl;

    int applied = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irqc_top uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_evt(src_evt), .irq_lvl(irq_lvl)
    );

    // op: 0 idle, 1 write, 2 read. Checks see state before the vector's edge.
    localparam int NV = 36;
    localparam logic [45:0] VEC [NV] = '{
        {2'd2, 8'h30, 8'h00, 16'h0000, 8'h00, 4'h0}, // R8 reset flag
        {2'd2, 8'h34, 8'h00, 16'h0000, 8'h00, 4'h0}, // R8 reset enable
        {2'd0, 8'h00, 8'h00, 16'h0001, 8'h00, 4'h0}, // R2 edge, disabled
        {2'd2, 8'h30, 8'h00, 16'h0001, 8'h01, 4'h0}, // R2 flag set while masked
        {2'd1, 8'h34, 8'h81, 16'h0001, 8'h00, 4'h0}, // R4 set en bit0
        {2'd2, 8'h34, 8'h00, 16'h0001, 8'h01, 4'h1}, // R4 R7 request up
        {2'd1, 8'h30, 8'h00, 16'h0001, 8'h00, 4'h1}, // R3 write zero
        {2'd2, 8'h30, 8'h00, 16'h0000, 8'h01, 4'h1}, // R3 flag kept
        {2'd1, 8'h30, 8'h01, 16'h0000, 8'h00, 4'h1}, // R3 clear by one
        {2'd2, 8'h30, 8'h00, 16'h0000, 8'h00, 4'h0}, // R7 request dropped
        {2'd0, 8'h00, 8'h00, 16'h0001, 8'h00, 4'h0}, // R2 new edge
        {2'd0, 8'h00, 8'h00, 16'h0001, 8'h00, 4'h1}, // R7 request back
        {2'd1, 8'h30, 8'h01, 16'h0001, 8'h00, 4'h1}, // R3 clear, level held
        {2'd2, 8'h30, 8'h00, 16'h0001, 8'h00, 4'h0}, // R2 held level no reset
        {2'd1, 8'h64, 8'h8C, 16'h0001, 8'h00, 4'h0}, // R4 bank3 en 1100
        {2'd0, 8'h00, 8'h00, 16'h4001, 8'h00, 4'h0}, // R2 bank3 bit2 edge
        {2'd2, 8'h60, 8'h00, 16'h4001, 8'h04, 4'h8}, // R1 R7 level 6 line
        {2'd1, 8'h64, 8'h04, 16'h4001, 8'h00, 4'h8}, // R5 clear en bit2
        {2'd2, 8'h64, 8'h00, 16'h4001, 8'h08, 4'h0}, // R5 bit3 kept, masked
        {2'd2, 8'h60, 8'h00, 16'h4001, 8'h04, 4'h0}, // R5 flag untouched
        {2'd1, 8'h60, 8'h08, 16'hC001, 8'h00, 4'h0}, // R6 edge + clear bit3
        {2'd2, 8'h60, 8'h00, 16'hC001, 8'h0C, 4'h8}, // R6 event wins
        {2'd1, 8'h44, 8'h8F, 16'hC001, 8'h00, 4'h8}, // R1 bank1 enables
        {2'd0, 8'h00, 8'h00, 16'hC021, 8'h00, 4'h8}, // R2 bank1 bit1 edge
        {2'd2, 8'h40, 8'h00, 16'hC021, 8'h02, 4'hA}, // R1 R7 bank1 read
        {2'd1, 8'h54, 8'h8F, 16'hC021, 8'h00, 4'hA}, // R1 bank2 enables
        {2'd0, 8'h00, 8'h00, 16'hC421, 8'h00, 4'hA}, // R2 bank2 bit2 edge
        {2'd2, 8'h50, 8'h00, 16'hC421, 8'h04, 4'hE}, // R1 bank2 read
        {2'd1, 8'h70, 8'h8F, 16'hC421, 8'h00, 4'hE}, // R1 unmapped page write
        {2'd2, 8'h70, 8'h00, 16'hC421, 8'h00, 4'hE}, // R1 unmapped read zero
        {2'd1, 8'h38, 8'hFF, 16'hC421, 8'h00, 4'hE}, // R1 unmapped slot write
        {2'd2, 8'h34, 8'h00, 16'hC421, 8'h01, 4'hE}, // R1 R8 en0 unchanged
        {2'd1, 8'h44, 8'h0F, 16'hC421, 8'h00, 4'hE}, // R9 mask bank1
        {2'd1, 8'h40, 8'h0F, 16'hC421, 8'h00, 4'hC}, // R9 clear bank1 flags
        {2'd2, 8'h40, 8'h00, 16'hC421, 8'h00, 4'hC}, // R9 flags zero
        {2'd2, 8'h44, 8'h00, 16'hC421, 8'h00, 4'hC}  // R9 enables zero
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        applied++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [7:0] a,
                         input logic [7:0] d, input logic [15:0] s);
        bus_sel   = (op != 2'd0);
        bus_we    = (op == 2'd1);
        bus_addr  = a;
        bus_wdata = d;
        src_evt   = s;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][45:44], VEC[i][43:36], VEC[i][35:28], VEC[i][27:12]);
            #1;
            check($sformatf("vec%0d irq R7", i), {4'h0, irq_lvl}, {4'h0, VEC[i][3:0]});
            if (VEC[i][45:44] == 2'd2)
                check($sformatf("vec%0d rdata R1/R8", i), bus_rdata, VEC[i][11:4]);
        end
        // Directed: reset in mid-run clears everything (R8)
        @(negedge clk);
        drive(2'd2, 8'h64, 8'h00, 16'h0000);
        rst_n = 1'b0;
        #1;
        check("R8 irq in reset", {4'h0, irq_lvl}, 8'h00);
        check("R8 en3 in reset", bus_rdata, 8'h00);
        @(negedge clk) rst_n = 1'b1;
        drive(2'd2, 8'h60, 8'h00, 16'h0000);
        #1;
        check("R8 flag3 after reset", bus_rdata, 8'h00);
        @(negedge clk);
        drive(2'd2, 8'h54, 8'h00, 16'h0000);
        #1;
        check("R8 en2 after reset", bus_rdata, 8'h00);
        check("R8 irq after reset", {4'h0, irq_lvl}, 8'h00);
        // Directed R2/R6: edge on enabled source in bank0 bit3 with same-cycle clear
        @(negedge clk) drive(2'd1, 8'h34, 8'h88, 16'h0000);
        @(negedge clk) drive(2'd1, 8'h30, 8'h08, 16'h0008);
        @(negedge clk) drive(2'd2, 8'h30, 8'h00, 16'h0008);
        #1;
        check("R6 bank0 flag kept", bus_rdata, 8'h08);
        check("R7 bank0 request", {4'h0, irq_lvl}, 8'h01);
        @(negedge clk) drive(2'd0, 8'h00, 8'h00, 16'h0000);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
            $finish;
        end
    end
endmodule